// File: doc/BRIEF.md
# Chained Converter Frame Receiver

This block sits at the host end of a serial chain of sigma-delta converters that all share one serial clock. It watches two lines driven by the converter closest to the host: the serial data line and the frame-sync line. A frame opens when frame-sync falls. From that bit on, the block assembles 32-bit words MSB first. It hands each finished word out with the position of its device in the chain and a one-cycle valid strobe.

The serial clock reaches the block as a bit-enable pulse `bit_en` that is synchronous to `clk`. Each cycle in which `bit_en` is high samples one bit of `sdata` and one of `fsync`.

The host sets two values. A decimation select fixes how many words fit into one conversion period, which is the decimation ratio divided by 32. A device count gives the number of converters actually wired into the chain. A device count that does not fit raises a configuration error, and no frame starts while that error is present.

While a frame is running, the block checks the frame-sync shape:
- Frame-sync must be low for exactly the 32 bits of the first word.
- Frame-sync must then be high for every later word.

Any breach of this shape pulses an error flag, and the rest of the frame is thrown away.

Top module: `chain_frame_rx`

## Requirements
- R1: Out of reset, `word_valid` and `frame_err` are low and the receiver waits for a frame-sync falling edge.
- R2: A frame starts on a sampled bit where `fsync` is low and the previous sampled `fsync` was high. That bit is the MSB of the word with index 0.
- R3: Each word holds 32 sampled bits, MSB first. `word_valid` is high for one `clk` cycle, in the cycle after the 32nd bit is sampled, together with `word_data`. `word_idx` counts 0, 1, 2 and so on in chain order.
- R4: A frame delivers exactly `dev_count` words. Later bits are ignored until the next falling edge, even if `fsync` stays high.
- R5: The chain limit is 2 for `dec_sel`=0 (ratio 64), 4 for `dec_sel`=1 (ratio 128) and 8 for `dec_sel`=2 (ratio 256). `dec_sel`=3 is reserved and has a limit of 0. `cfg_err` is high when `dev_count` is 0 or above the limit. While `cfg_err` is high, no frame starts.
- R6: If `fsync` is sampled high during word 0, `frame_err` pulses and word 0 is not delivered.
- R7: If `fsync` is still low on the first bit of word 1, `frame_err` pulses. Word 0 has already been delivered by then.
- R8: A falling edge of `fsync` before all `dev_count` words have arrived pulses `frame_err`, and that edge starts a new frame.
- R9: After an error, no word is delivered until the next falling edge of `fsync`.
- R10: `frame_err` and `word_valid` are never high in the same cycle, and each is high for one cycle at a time.
- R11: Cycles with `bit_en` low sample nothing and change no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One pulse per serial bit, synchronous to clk |
| sdata | input | 1 | Serial data from the first device in the chain |
| fsync | input | 1 | Frame-sync from the first device in the chain |
| dec_sel | input | 2 | Decimation select: 0=64, 1=128, 2=256, 3=reserved |
| dev_count | input | 4 | Number of devices in the chain |
| word_data | output | 32 | Assembled word |
| word_idx | output | 3 | Chain position of the word |
| word_valid | output | 1 | One-cycle strobe for word_data and word_idx |
| frame_err | output | 1 | One-cycle pulse on a frame-sync timing error |
| cfg_err | output | 1 | Device count not allowed for the selected decimation |

## Verification
The assertions check on every cycle the properties that hold regardless of the data:
- the valid and error strobes each last one cycle and never coincide;
- a valid strobe follows only a sampled bit;
- a frame that has started has its bit counter positioned after the MSB;
- the word counter stays below the configured device count.

Only the bench scenarios can show the rest:
- that the words carry the right bits in the right order;
- that the chain limit is right for each decimation setting;
- that each kind of frame-sync fault is caught at the right bit;
- that the receiver recovers on the next falling edge after an error.

// File: rtl/cfr_pkg.sv
package cfr_pkg;

  typedef enum logic {
    ST_WAIT = 1'b0,
    ST_RUN  = 1'b1
  } rx_state_t;

  // Words per conversion period = decimation ratio / word length.
  // Select 0,1,2 -> ratio 64,128,256; select 3 is reserved (limit 0).
  function automatic logic [15:0] chain_limit(input logic [1:0] sel,
                                              input logic [15:0] word_bits);
    logic [15:0] ratio;
    ratio = 16'd64 << sel;
    if (sel == 2'd3) return 16'd0;
    return ratio / word_bits;
  endfunction

endpackage

// File: rtl/cfr_sync_mon.sv
module cfr_sync_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic fsync,
  output logic fs_fall
);
  logic fs_prev;

  always_ff @(posedge clk) begin
    if (!rst_n)      fs_prev <= 1'b1;
    else if (bit_en) fs_prev <= fsync;
  end

  assign fs_fall = bit_en && fs_prev && !fsync;

endmodule

// File: rtl/cfr_deser.sv
module cfr_deser #(
  parameter int WORD_BITS = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_en,
  input  logic                 sdata,
  output logic [WORD_BITS-1:0] word_next
);
  logic [WORD_BITS-2:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n)      sh <= '0;
    else if (bit_en) sh <= {sh[WORD_BITS-3:0], sdata};
  end

  // The word as it will stand once the bit now on sdata is taken in.
  assign word_next = {sh, sdata};

endmodule

// File: rtl/cfr_cfg_chk.sv
module cfr_cfg_chk
  import cfr_pkg::*;
#(
  parameter int WORD_BITS = 32,
  parameter int MAX_DEV   = 8,
  parameter int CNT_W     = $clog2(MAX_DEV + 1)
) (
  input  logic [1:0]       dec_sel,
  input  logic [CNT_W-1:0] dev_count,
  output logic [CNT_W-1:0] frame_words,
  output logic             cfg_err
);
  logic [15:0] limit;

  assign limit       = chain_limit(dec_sel, 16'(WORD_BITS));
  assign frame_words = dev_count;
  assign cfg_err     = (dev_count == '0) ||
                       (16'(dev_count) > limit) ||
                       (16'(dev_count) > 16'(MAX_DEV));

endmodule

// File: rtl/cfr_ctrl.sv
module cfr_ctrl
  import cfr_pkg::*;
#(
  parameter int WORD_BITS = 32,
  parameter int MAX_DEV   = 8,
  parameter int CNT_W     = $clog2(MAX_DEV + 1),
  parameter int IDX_W     = $clog2(MAX_DEV)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_en,
  input  logic                 fsync,
  input  logic                 fs_fall,
  input  logic                 cfg_err,
  input  logic [CNT_W-1:0]     frame_words,
  input  logic [WORD_BITS-1:0] word_next,
  output logic [WORD_BITS-1:0] word_data,
  output logic [IDX_W-1:0]     word_idx,
  output logic                 word_valid,
  output logic                 frame_err
);
  localparam int BC_W = $clog2(WORD_BITS);

  rx_state_t        state;
  logic [BC_W-1:0]  bcnt;
  logic [CNT_W-1:0] wcnt;

  logic running, in_word0, last_bit, last_word;
  logic start, bad_rise, bad_low, err_now, word_done;

  assign running   = (state == ST_RUN);
  assign in_word0  = (wcnt == '0);
  assign last_bit  = (bcnt == BC_W'(WORD_BITS - 1));
  assign last_word = (wcnt == frame_words - CNT_W'(1));
  assign start     = fs_fall && !cfg_err;
  // frame-sync high inside word 0: rose too early
  assign bad_rise  = bit_en && running && in_word0 && fsync;
  // frame-sync low after word 0: rose too late, or fell too early
  assign bad_low   = bit_en && running && !in_word0 && !fsync;
  assign err_now   = bad_rise || bad_low;
  assign word_done = bit_en && running && last_bit && !err_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_WAIT;
      bcnt       <= '0;
      wcnt       <= '0;
      word_data  <= '0;
      word_idx   <= '0;
      word_valid <= 1'b0;
      frame_err  <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      frame_err  <= 1'b0;
      if (bit_en) begin
        if (err_now) begin
          frame_err <= 1'b1;
          state     <= ST_WAIT;
        end
        if (start) begin
          state <= ST_RUN;
          bcnt  <= BC_W'(1);
          wcnt  <= '0;
        end else if (running && !err_now) begin
          if (last_bit) begin
            bcnt       <= '0;
            word_valid <= 1'b1;
            word_data  <= word_next;
            word_idx   <= wcnt[IDX_W-1:0];
            if (last_word) state <= ST_WAIT;
            else           wcnt  <= wcnt + CNT_W'(1);
          end else begin
            bcnt <= bcnt + BC_W'(1);
          end
        end
      end
    end
  end

  // R3
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);
  // R10
  err_valid_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(word_valid && frame_err));
  // R11
  valid_after_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> $past(bit_en));
  // R2
  start_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (state == ST_RUN) && (bcnt == BC_W'(1)));
  // R4
  word_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN) && $stable(frame_words) |-> wcnt < frame_words);
  // R10
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err && !$past(start) |-> state == ST_WAIT);

endmodule

// File: rtl/chain_frame_rx.sv
module chain_frame_rx #(
  parameter int WORD_BITS = 32,
  parameter int MAX_DEV   = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           bit_en,
  input  logic                           sdata,
  input  logic                           fsync,
  input  logic [1:0]                     dec_sel,
  input  logic [$clog2(MAX_DEV+1)-1:0]   dev_count,
  output logic [WORD_BITS-1:0]           word_data,
  output logic [$clog2(MAX_DEV)-1:0]     word_idx,
  output logic                           word_valid,
  output logic                           frame_err,
  output logic                           cfg_err
);
  localparam int CNT_W = $clog2(MAX_DEV + 1);
  localparam int IDX_W = $clog2(MAX_DEV);

  logic                 fs_fall;
  logic [WORD_BITS-1:0] word_next;
  logic [CNT_W-1:0]     frame_words;

  cfr_sync_mon u_sync (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fsync(fsync), .fs_fall(fs_fall)
  );

  cfr_deser #(.WORD_BITS(WORD_BITS)) u_deser (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .sdata(sdata), .word_next(word_next)
  );

  cfr_cfg_chk #(.WORD_BITS(WORD_BITS), .MAX_DEV(MAX_DEV), .CNT_W(CNT_W)) u_cfg (
    .dec_sel(dec_sel), .dev_count(dev_count),
    .frame_words(frame_words), .cfg_err(cfg_err)
  );

  cfr_ctrl #(.WORD_BITS(WORD_BITS), .MAX_DEV(MAX_DEV), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fsync(fsync), .fs_fall(fs_fall),
    .cfg_err(cfg_err), .frame_words(frame_words), .word_next(word_next),
    .word_data(word_data), .word_idx(word_idx), .word_valid(word_valid),
    .frame_err(frame_err)
  );

endmodule

// File: tb/tb_chain_frame_rx.sv
module tb_chain_frame_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_en = 1'b0;
  logic        sdata = 1'b0;
  logic        fsync = 1'b1;
  logic [1:0]  dec_sel = 2'd0;
  logic [3:0]  dev_count = 4'd1;
  logic [31:0] word_data;
  logic [2:0]  word_idx;
  logic        word_valid, frame_err, cfg_err;

  int total = 0, fails = 0;
  int got_n = 0, err_seen = 0;
  logic [31:0] got_d [16];
  logic [2:0]  got_i [16];

  always #4 clk = ~clk;

  chain_frame_rx dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .sdata(sdata), .fsync(fsync),
    .dec_sel(dec_sel), .dev_count(dev_count), .word_data(word_data),
    .word_idx(word_idx), .word_valid(word_valid), .frame_err(frame_err),
    .cfg_err(cfg_err)
  );

  always @(negedge clk) begin
    if (rst_n && word_valid) begin
      if (got_n < 16) begin
        got_d[got_n] = word_data;
        got_i[got_n] = word_idx;
      end
      got_n = got_n + 1;
    end
    if (rst_n && frame_err) err_seen = err_seen + 1;
  end

  function automatic logic [31:0] exp_word(input int f, input int d);
    logic [31:0] s;
    s = 32'(f * 8 + d + 1);
    return (s * 32'h9E3779B9) ^ {s[7:0], 24'h5A3C00};
  endfunction

  function automatic int limit_of(input int sel);
    return (sel == 3) ? 0 : (64 << sel) / 32;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total = total + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic d, input logic fs);
    @(negedge clk);
    bit_en = 1'b1; sdata = d; fsync = fs;
    @(negedge clk);
    bit_en = 1'b0;
    @(negedge clk);
  endtask

  // kind 0 good, 1 early rise in word 0, 2 late rise at word 1
  task automatic send_frame(input int n, input int kind, input int f);
    logic [31:0] w_val;
    logic fs;
    send_bit(1'b0, 1'b1);
    for (int w = 0; w < n; w++) begin
      w_val = exp_word(f, w);
      for (int b = 0; b < 32; b++) begin
        fs = (w == 0) ? 1'b0 : 1'b1;
        if (kind == 1 && w == 0 && b >= 10) fs = 1'b1;
        if (kind == 2 && w == 1 && b == 0) fs = 1'b0;
        send_bit(w_val[31-b], fs);
      end
    end
    repeat (2) send_bit(1'b1, 1'b1);
  endtask

  task automatic clear_obs();
    got_n = 0; err_seen = 0;
  endtask

  task automatic check_words(input string req, input int first, input int n, input int f);
    for (int k = 0; k < n; k++) begin
      check(got_d[first+k] == exp_word(f, k) && got_i[first+k] == 3'(k), req,
            {got_i[first+k], got_d[first+k]}, {3'(k), exp_word(f, k)});
    end
  endtask

  initial begin
    repeat (5000000) @(posedge clk);
    total = total + 1; fails = fails + 1;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int fr;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(!word_valid && !frame_err, "R1", {word_valid, frame_err}, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(!word_valid && !frame_err && !cfg_err, "R1 R11 idle", {word_valid, frame_err, cfg_err}, 0);

    // R2 R3 R4 R5: sweep every legal device count for each decimation select
    fr = 0;
    for (int sel = 0; sel < 3; sel++) begin
      for (int dc = 1; dc <= limit_of(sel); dc++) begin
        dec_sel = 2'(sel); dev_count = 4'(dc);
        @(negedge clk);
        check(!cfg_err, "R5 legal config", cfg_err, 0);
        clear_obs();
        send_frame(dc, 0, fr);
        check(got_n == dc && err_seen == 0, "R4 word count", got_n, dc);
        check_words("R2 R3 word content", 0, dc, fr);
        fr++;
      end
    end

    // R5 illegal configurations block frames
    dec_sel = 2'd1; dev_count = 4'd5; @(negedge clk);
    check(cfg_err, "R5 over limit 128", cfg_err, 1);
    clear_obs(); send_frame(5, 0, 50);
    check(got_n == 0 && err_seen == 0, "R5 no frame when cfg_err", got_n, 0);
    dec_sel = 2'd0; dev_count = 4'd3; @(negedge clk);
    check(cfg_err, "R5 over limit 64", cfg_err, 1);
    dec_sel = 2'd3; dev_count = 4'd1; @(negedge clk);
    check(cfg_err, "R5 reserved select", cfg_err, 1);
    dec_sel = 2'd2; dev_count = 4'd0; @(negedge clk);
    check(cfg_err, "R5 zero devices", cfg_err, 1);

    // R4 extra bits after last word are ignored
    dec_sel = 2'd1; dev_count = 4'd2; @(negedge clk);
    clear_obs(); send_frame(3, 0, 60);
    check(got_n == 2 && err_seen == 0, "R4 extra word ignored", got_n, 2);
    check_words("R4 content", 0, 2, 60);

    dev_count = 4'd4; @(negedge clk);
    // R6 early rise then R9 discard
    clear_obs(); send_frame(4, 1, 70);
    check(got_n == 0, "R6 R9 no words after early rise", got_n, 0);
    check(err_seen == 1, "R6 error pulse", err_seen, 1);
    clear_obs(); send_frame(4, 0, 71);
    check(got_n == 4 && err_seen == 0, "R9 recovery", got_n, 4);
    check_words("R9 recovery content", 0, 4, 71);

    // R7 late rise
    clear_obs(); send_frame(4, 2, 72);
    check(got_n == 1, "R7 word 0 kept", got_n, 1);
    check(err_seen == 1, "R7 error pulse", err_seen, 1);
    check_words("R7 word 0 content", 0, 1, 72);

    // R8 early fall restarts the frame
    clear_obs(); send_frame(2, 0, 73);
    send_frame(4, 0, 74);
    check(err_seen == 1, "R8 error pulse", err_seen, 1);
    check(got_n == 6, "R8 words", got_n, 6);
    check_words("R8 partial frame", 0, 2, 73);
    check_words("R8 restarted frame", 2, 4, 74);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule